// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block turns the system clock into CAN time quanta and places the two points that matter inside each bit time. The sample point is where the receive value is captured. The transmit point is where a new bit begins. Every timing parameter arrives as a register field stored minus one. A divide-by-two pre-stage can slow the quantum clock for low bit rates. An optional three-vote sampler suppresses short glitches on the receive line.

Each bit time has three parts: one sync quantum, a first phase segment of TSEG1 quanta and a second phase segment of TSEG2 quanta. The sample point is the end of the first phase segment. A recessive-to-dominant transition of the receive line moves the bit boundary. While the surrounding frame logic allows hard synchronisation, the transition restarts the bit. Otherwise the block resynchronises softly, stretching the first phase or cutting short the second by no more than SJW quanta.

The timing fields are captured only while the configuration enable is high. While it is high, the quantum and phase machinery is held idle and no strobes are produced. The block has no data stream. All pins are plain control and status lines, and no pin carries back-pressure.

Top module: `can_bit_timer`

## Requirements
- R1: With `div2_en` low, `tq_stb` is a one-cycle pulse repeating every 2*(`brp_code`+1) clock cycles. The first pulse comes 2*(`brp_code`+1) cycles after `cfg_en` falls.
- R2: With `div2_en` high, the pulse period becomes 4*(`brp_code`+1) clock cycles.
- R3: With no edge on the receive line, a bit lasts 1+(`tseg1_code`+1)+(`tseg2_code`+1) quanta. `sample_stb` pulses one cycle after the quantum strobe that closes the last first-phase quantum. `tx_stb` pulses one cycle after the quantum strobe that closes the last second-phase quantum. The two strobes never coincide.
- R4: With `triple_en` low, `rx_bit` takes the value of `rx_in` at the sample quantum strobe. It keeps that value until the next sample.
- R5: With `triple_en` high, `rx_bit` becomes the 2-of-3 majority of `rx_in` at the sample quantum strobe and at the two quantum strobes before it.
- R6: An edge is `rx_in` at 0 on a quantum strobe after 1 on the previous quantum strobe. A soft edge in the quantum that is k quanta into the first phase (k counted from 1) stretches that phase by min(k, `sjw_code`+1). At most one soft resynchronisation happens per bit. Edges in the sync quantum are ignored.
- R7: Let r be the number of second-phase quanta left, counting the edge quantum. For a soft edge in the second phase with r no greater than `sjw_code`+1, the edge quantum ends the bit and `tx_stb` follows. Otherwise the second phase is shortened by `sjw_code`+1.
- R8: While `hard_sync_en` is high, an edge in any segment makes the edge quantum the sync quantum of a new bit. Both phases return to nominal length and `tx_stb` pulses one cycle later.
- R9: The timing fields take effect only while `cfg_en` is high, and changes at other times are ignored. While `cfg_en` is high, no strobe is produced and `rx_bit` holds its value.
- R10: After reset all strobes are low, `rx_bit` is 1 and all fields read as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration enable: latches the fields and holds the timing idle |
| brp_code | input | 6 | Prescaler field, effective prescale = 2*(code+1) |
| div2_en | input | 1 | Halve the clock ahead of the prescaler |
| sjw_code | input | 2 | Jump width minus one |
| tseg1_code | input | 4 | First phase length minus one |
| tseg2_code | input | 3 | Second phase length minus one |
| triple_en | input | 1 | Three-vote sampling enable |
| hard_sync_en | input | 1 | Edges restart the bit rather than resynchronising it |
| rx_in | input | 1 | Synchronised receive line, 1 = recessive |
| tq_stb | output | 1 | Time quantum strobe |
| sample_stb | output | 1 | Sample point strobe |
| tx_stb | output | 1 | Bit start (transmit point) strobe |
| rx_bit | output | 1 | Sampled bit value |

## Verification
The bench aims at four cases. The first is an edge in the last first-phase quantum: a design that tests the end of the phase before applying the stretch would sample early. The second is an edge in the second phase when the quanta left exactly equal SJW: an off-by-one there shortens the phase rather than restarting the bit, and the transmit point drifts. Third, tiny segments with the largest jump width, and the largest prescale with the pre-divider on, expose wrong clamping and counter widths. Fourth, field changes while running must leave the timing untouched, and the vote must use exactly the two quanta before the sample point.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [BRP_W-1:0] brp_in,
  input  logic             div2_in,
  input  logic [SJW_W-1:0] sjw_in,
  input  logic [T1_W-1:0]  t1_in,
  input  logic [T2_W-1:0]  t2_in,
  input  logic             tri_in,
  output logic [BRP_W-1:0] brp_q,
  output logic             div2_q,
  output logic [SJW_W-1:0] sjw_q,
  output logic [T1_W-1:0]  t1_q,
  output logic [T2_W-1:0]  t2_q,
  output logic             tri_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brp_q  <= '0;
      div2_q <= 1'b0;
      sjw_q  <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      tri_q  <= 1'b0;
    end else if (cfg_en) begin
      brp_q  <= brp_in;
      div2_q <= div2_in;
      sjw_q  <= sjw_in;
      t1_q   <= t1_in;
      t2_q   <= t2_in;
      tri_q  <= tri_in;
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable({brp_q, div2_q, sjw_q, t1_q, t2_q, tri_q}));

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W      = 6,
  parameter bit USE_PREDIV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp_code,
  input  logic             div2_en,
  output logic             tq_pulse
);

  localparam int CW = BRP_W + 1;

  logic          pre_en;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q;

  generate
    if (USE_PREDIV) begin : g_prediv
      logic tog_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog_q <= 1'b0;
        else if (hold) tog_q <= 1'b0;
        else           tog_q <= ~tog_q;
      end
      assign pre_en = div2_en ? tog_q : 1'b1;
    end else begin : g_noprediv
      assign pre_en = 1'b1;
    end
  endgenerate

  assign lim = {brp_code, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tq_pulse <= 1'b0;
    end else if (hold) begin
      cnt_q    <= '0;
      tq_pulse <= 1'b0;
    end else if (pre_en && cnt_q == lim) begin
      cnt_q    <= '0;
      tq_pulse <= 1'b1;
    end else begin
      if (pre_en) cnt_q <= cnt_q + CW'(1);
      tq_pulse <= 1'b0;
    end
  end

  assert_tq_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tq_pulse |=> !tq_pulse);

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic rx_in,
  input  logic capture,
  input  logic triple_en,
  output logic last_rx,
  output logic rx_bit
);

  logic h1_q, h0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q <= 1'b1;
      h0_q <= 1'b1;
    end else if (hold) begin
      h1_q <= 1'b1;
      h0_q <= 1'b1;
    end else if (tick) begin
      h1_q <= rx_in;
      h0_q <= h1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rx_bit <= 1'b1;
    else if (!hold && tick && capture)
      rx_bit <= triple_en ? vote3(rx_in, h1_q, h0_q) : rx_in;
  end

  assign last_rx = h1_q;

  assert_bit_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rx_bit));

endmodule

// File: rtl/cbt_phase_fsm.sv
module cbt_phase_fsm
  import cbt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             rx_in,
  input  logic             last_rx,
  input  logic             hard_sync_en,
  input  logic [SJW_W-1:0] sjw_code,
  input  logic [T1_W-1:0]  t1_code,
  input  logic [T2_W-1:0]  t2_code,
  output logic             capture,
  output logic             sample_stb,
  output logic             tx_stb
);

  localparam int T1_MAX  = 1 << T1_W;
  localparam int SJW_MAX = 1 << SJW_W;
  localparam int W       = $clog2(T1_MAX + SJW_MAX + 1);

  seg_e         seg_q, seg_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] ext_q, ext_d;
  logic [W-1:0] cut_q, cut_d;
  logic         done_q, done_d;
  logic         smp_d, tx_d;

  logic [W-1:0] t1_nom, t2_nom, sjw;
  logic [W-1:0] p1_len, p2_len, p1_eff, p2_eff;
  logic [W-1:0] ph_err, rem2, add;
  logic         fall, restart;

  assign t1_nom = W'(t1_code) + W'(1);
  assign t2_nom = W'(t2_code) + W'(1);
  assign sjw    = W'(sjw_code) + W'(1);
  assign p1_len = t1_nom + ext_q;
  assign p2_len = t2_nom - cut_q;
  assign ph_err = cnt_q + W'(1);
  assign rem2   = p2_len - cnt_q;
  assign fall   = last_rx & ~rx_in;

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    ext_d   = ext_q;
    cut_d   = cut_q;
    done_d  = done_q;
    smp_d   = 1'b0;
    tx_d    = 1'b0;
    capture = 1'b0;
    restart = 1'b0;
    add     = '0;
    p1_eff  = p1_len;
    p2_eff  = p2_len;
    if (tick) begin
      if (fall && hard_sync_en) begin
        restart = 1'b1;
      end else if (fall && !done_q) begin
        if (seg_q == SEG_PH1) begin
          add    = (ph_err < sjw) ? ph_err : sjw;
          ext_d  = ext_q + add;
          p1_eff = p1_len + add;
          done_d = 1'b1;
        end else if (seg_q == SEG_PH2) begin
          done_d = 1'b1;
          if (rem2 <= sjw) begin
            restart = 1'b1;
          end else begin
            cut_d  = cut_q + sjw;
            p2_eff = p2_len - sjw;
          end
        end
      end
      if (restart) begin
        seg_d  = SEG_PH1;
        cnt_d  = '0;
        ext_d  = '0;
        cut_d  = '0;
        done_d = 1'b0;
        tx_d   = 1'b1;
      end else begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_PH1;
            cnt_d = '0;
          end
          SEG_PH1: begin
            if (ph_err == p1_eff) begin
              capture = 1'b1;
              smp_d   = 1'b1;
              seg_d   = SEG_PH2;
              cnt_d   = '0;
            end else begin
              cnt_d = ph_err;
            end
          end
          SEG_PH2: begin
            if (ph_err == p2_eff) begin
              seg_d  = SEG_SYNC;
              cnt_d  = '0;
              ext_d  = '0;
              cut_d  = '0;
              done_d = 1'b0;
              tx_d   = 1'b1;
            end else begin
              cnt_d = ph_err;
            end
          end
          default: begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q      <= SEG_SYNC;
      cnt_q      <= '0;
      ext_q      <= '0;
      cut_q      <= '0;
      done_q     <= 1'b0;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else if (hold) begin
      seg_q      <= SEG_SYNC;
      cnt_q      <= '0;
      ext_q      <= '0;
      cut_q      <= '0;
      done_q     <= 1'b0;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else begin
      seg_q      <= seg_d;
      cnt_q      <= cnt_d;
      ext_q      <= ext_d;
      cut_q      <= cut_d;
      done_q     <= done_d;
      sample_stb <= smp_d;
      tx_stb     <= tx_d;
    end
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  assert_ph1_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_PH1) |-> (cnt_q < p1_len));

  assert_stretch_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= sjw);

  assert_single_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q != '0 || cut_q != '0) |-> done_q);

  assert_idle_in_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sample_stb && !tx_stb));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W      = 6,
  parameter int SJW_W      = 2,
  parameter int T1_W       = 4,
  parameter int T2_W       = 3,
  parameter bit USE_PREDIV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [BRP_W-1:0] brp_code,
  input  logic             div2_en,
  input  logic [SJW_W-1:0] sjw_code,
  input  logic [T1_W-1:0]  tseg1_code,
  input  logic [T2_W-1:0]  tseg2_code,
  input  logic             triple_en,
  input  logic             hard_sync_en,
  input  logic             rx_in,
  output logic             tq_stb,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             rx_bit
);

  logic [BRP_W-1:0] brp_q;
  logic             div2_q;
  logic [SJW_W-1:0] sjw_q;
  logic [T1_W-1:0]  t1_q;
  logic [T2_W-1:0]  t2_q;
  logic             tri_q;
  logic             tq_pulse;
  logic             last_rx;
  logic             capture;

  cbt_cfg_regs #(
    .BRP_W(BRP_W), .SJW_W(SJW_W), .T1_W(T1_W), .T2_W(T2_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .brp_in(brp_code), .div2_in(div2_en), .sjw_in(sjw_code),
    .t1_in(tseg1_code), .t2_in(tseg2_code), .tri_in(triple_en),
    .brp_q(brp_q), .div2_q(div2_q), .sjw_q(sjw_q),
    .t1_q(t1_q), .t2_q(t2_q), .tri_q(tri_q)
  );

  cbt_prescaler #(
    .BRP_W(BRP_W), .USE_PREDIV(USE_PREDIV)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en),
    .brp_code(brp_q), .div2_en(div2_q), .tq_pulse(tq_pulse)
  );

  cbt_phase_fsm #(
    .SJW_W(SJW_W), .T1_W(T1_W), .T2_W(T2_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .tick(tq_pulse),
    .rx_in(rx_in), .last_rx(last_rx), .hard_sync_en(hard_sync_en),
    .sjw_code(sjw_q), .t1_code(t1_q), .t2_code(t2_q),
    .capture(capture), .sample_stb(sample_stb), .tx_stb(tx_stb)
  );

  cbt_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .tick(tq_pulse),
    .rx_in(rx_in), .capture(capture), .triple_en(tri_q),
    .last_rx(last_rx), .rx_bit(rx_bit)
  );

  assign tq_stb = tq_pulse;

endmodule

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic [5:0] brp_code = '0;
  logic       div2_en = 1'b0;
  logic [1:0] sjw_code = '0;
  logic [3:0] tseg1_code = '0;
  logic [2:0] tseg2_code = '0;
  logic       triple_en = 1'b0;
  logic       hard_sync_en = 1'b0;
  logic       rx_in = 1'b1;
  logic       tq_stb, sample_stb, tx_stb, rx_bit;

  always #10 clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .brp_code(brp_code),
    .div2_en(div2_en), .sjw_code(sjw_code), .tseg1_code(tseg1_code),
    .tseg2_code(tseg2_code), .triple_en(triple_en), .hard_sync_en(hard_sync_en),
    .rx_in(rx_in), .tq_stb(tq_stb), .sample_stb(sample_stb), .tx_stb(tx_stb),
    .rx_bit(rx_bit)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    armed = 0;
  string cur_req = "R10";

  // reference model state
  int m_brp = 0, m_div2 = 0, m_sjw = 0, m_t1 = 0, m_t2 = 0, m_tri = 0;
  int pc = 0, tog = 0, tqp = 0;
  int seg = 0, cnt = 0, p1 = 1, p2 = 1, done = 0;
  int rlast = 1, h1 = 1, h0 = 1;
  int e_tq = 0, e_smp = 0, e_tx = 0, e_bit = 1;

  task automatic chk(input string what, input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: got %0d expected %0d at cycle %0d", tag, cur_req, what, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    armed = 1;
    if (!rst_n) begin
      m_brp = 0; m_div2 = 0; m_sjw = 0; m_t1 = 0; m_t2 = 0; m_tri = 0;
      pc = 0; tog = 0; tqp = 0; seg = 0; cnt = 0; p1 = 1; p2 = 1; done = 0;
      rlast = 1; h1 = 1; h0 = 1; e_tq = 0; e_smp = 0; e_tx = 0; e_bit = 1;
    end else if (cfg_en) begin
      m_brp = brp_code; m_div2 = div2_en; m_sjw = sjw_code;
      m_t1 = tseg1_code; m_t2 = tseg2_code; m_tri = triple_en;
      pc = 0; tog = 0; tqp = 0; seg = 0; cnt = 0; done = 0;
      p1 = m_t1 + 1; p2 = m_t2 + 1;
      rlast = 1; h1 = 1; h0 = 1; e_tq = 0; e_smp = 0; e_tx = 0;
    end else begin
      int smp, tx, r, fall, sj, rst_bit, en;
      smp = 0; tx = 0;
      if (tqp == 1) begin
        r = rx_in;
        fall = (rlast == 1 && r == 0);
        rlast = r;
        sj = m_sjw + 1;
        rst_bit = 0;
        if (fall && hard_sync_en) rst_bit = 1;
        else if (fall && !done) begin
          if (seg == 1) begin
            p1 += ((cnt + 1) < sj) ? (cnt + 1) : sj;
            done = 1;
          end else if (seg == 2) begin
            done = 1;
            if (p2 - cnt <= sj) rst_bit = 1;
            else p2 -= sj;
          end
        end
        if (rst_bit) begin
          seg = 1; cnt = 0; p1 = m_t1 + 1; p2 = m_t2 + 1; done = 0; tx = 1;
        end else if (seg == 0) begin
          seg = 1; cnt = 0;
        end else if (seg == 1) begin
          if (cnt + 1 == p1) begin
            smp = 1; seg = 2; cnt = 0;
            if (m_tri) e_bit = (r + h1 + h0 >= 2) ? 1 : 0;
            else e_bit = r;
          end else cnt++;
        end else begin
          if (cnt + 1 == p2) begin
            seg = 0; cnt = 0; p1 = m_t1 + 1; p2 = m_t2 + 1; done = 0; tx = 1;
          end else cnt++;
        end
        h0 = h1; h1 = r;
      end
      en = m_div2 ? tog : 1;
      tog = 1 - tog;
      tqp = 0;
      if (en) begin
        if (pc == 2 * (m_brp + 1) - 1) begin pc = 0; tqp = 1; end
        else pc++;
      end
      e_tq = tqp; e_smp = smp; e_tx = tx;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk("tq_stb", m_div2 ? "R2" : "R1", tq_stb, e_tq);
      chk("sample_stb", "R3", sample_stb, e_smp);
      chk("tx_stb", "R3", tx_stb, e_tx);
      chk("rx_bit", m_tri ? "R5" : "R4", rx_bit, e_bit);
    end
  end

  // stimulus
  int rx_per = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rx_per > 0 && (i % rx_per) == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rx_in = lfsr[0];
      end
    end
  endtask

  task automatic configure(input int b, input int d, input int s, input int t1,
                           input int t2, input int tr);
    @(negedge clk);
    cfg_en = 1'b1;
    brp_code = 6'(b); div2_en = d[0]; sjw_code = 2'(s);
    tseg1_code = 4'(t1); tseg2_code = 3'(t2); triple_en = tr[0];
    run(3);
    cfg_en = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    // R10: reset state seen at the ports
    repeat (3) @(negedge clk);
    chk("reset tq_stb", "R10", tq_stb, 0);
    chk("reset sample_stb", "R10", sample_stb, 0);
    chk("reset tx_stb", "R10", tx_stb, 0);
    chk("reset rx_bit", "R10", rx_bit, 1);
    rst_n = 1'b1;

    cur_req = "R1 R3";
    rx_per = 0; rx_in = 1'b1;
    configure(0, 0, 0, 2, 1, 0);
    run(150);

    cur_req = "R2";
    configure(3, 1, 1, 4, 2, 0);
    run(700);

    cur_req = "R4 R6 R7";
    rx_per = 3;
    configure(1, 0, 3, 7, 3, 0);
    run(1500);

    cur_req = "R5";
    configure(1, 0, 3, 7, 3, 1);
    run(1500);

    cur_req = "R7";
    rx_per = 2;
    configure(0, 0, 3, 0, 0, 0);
    run(800);

    cur_req = "R8";
    hard_sync_en = 1'b1;
    rx_per = 5;
    configure(2, 0, 1, 5, 4, 0);
    run(1200);
    hard_sync_en = 1'b0;

    // R9: field changes while running are ignored; cfg_en holds idle
    cur_req = "R9";
    configure(1, 0, 2, 6, 3, 0);
    run(200);
    brp_code = 6'd9; tseg1_code = 4'd1; tseg2_code = 3'd6; sjw_code = 2'd0;
    div2_en = 1'b1; triple_en = 1'b1;
    run(600);
    cfg_en = 1'b1;
    run(40);
    cfg_en = 1'b0;
    run(400);

    cur_req = "R1 R2 R6 R7";
    rx_per = 700;
    configure(63, 1, 3, 15, 7, 1);
    run(30000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule